// File: doc/BRIEF.md
# Overcurrent Fault Latch and Clear Timer

This block sits between a motor-drive controller's protection comparators and its six gate outputs. It watches a digital overcurrent trip bit and a low-side undervoltage bit. It raises an active-low fault indication and a shutdown request that forces every gate output off.

A trip bit only counts as an overcurrent once it has stayed high for a parameterised number of consecutive clock samples. A qualified overcurrent sets a set-dominant latch. The latch can clear only after the trip has gone away and a programmable countdown, given in clock cycles on `clr_len`, has run to its end. Every new qualified trip resets that countdown to zero. This stands in for an external timing capacitor that is discharged on a trip and then recharges slowly.

Undervoltage takes a different path. It drives the same fault output at once and is not latched. The fault lifts in the same cycle the undervoltage bit drops, unless an overcurrent latch is still holding it.

Top module: `ocp_fault_guard`

## Requirements
- R1: While `rst_n` is low, and after its release with `trip_raw` and `uv_flag` both low, `fault_n` is 1 and `shutdown` is 0. A reset taken while the overcurrent latch is set also returns `fault_n` to 1.
- R2: `trip_raw` becomes a qualified overcurrent only after it has been sampled high on FILT_CYC consecutive rising edges. Any low sample restarts the count, so shorter pulses leave `fault_n` at 1.
- R3: From the edge that qualifies a trip, `fault_n` is 0 and `shutdown` is 1 for as long as the trip stays qualified.
- R4: The latch is set-dominant. While `trip_raw` stays high, the fault holds no matter how small `clr_len` is.
- R5: Let edge F be the first edge that samples `trip_raw` low after a qualified trip. The fault then persists and lifts right after edge F+`clr_len`.
- R6: A new qualified trip that arrives during the countdown stops the countdown and keeps the fault asserted. Once that trip ends, the full `clr_len` delay is counted again from zero, measured from the new edge F.
- R7: `uv_flag` high forces `fault_n` to 0 combinationally, in the same cycle. When `uv_flag` falls, the fault lifts in that same cycle if no overcurrent is qualified or latched.
- R8: `shutdown` is always the exact complement of `fault_n`.
- R9: A `clr_len` of 0 behaves like 1: the fault lifts right after edge F+1. `clr_len` must be held stable while a countdown runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_raw | input | 1 | Overcurrent comparator bit, synchronous to `clk`, high = over threshold |
| uv_flag | input | 1 | Low-side undervoltage bit, high = supply below threshold |
| clr_len | input | DLY_W | Fault clear delay in clock cycles after the trip ends |
| fault_n | output | 1 | Active-low fault: overcurrent qualified or latched, or undervoltage |
| shutdown | output | 1 | Request to force all six gate outputs off |

## Verification
The bench sends trip bursts one sample shorter than the filter window. A design that counted non-consecutive samples, or was off by one in the filter, would raise a fault on them. A second trip that lands in the middle of a long countdown exposes a timer that only pauses, or keeps running, instead of restarting from zero; such a design would lift the fault about ten cycles early. A trip held long with a tiny clear delay catches a latch that is not set-dominant, which would drop the fault while the trip is still present. Undervoltage that toggles during a countdown shows whether release is immediate or wrongly latched. A `clr_len` of 0 shows whether it wraps to a very long delay.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    // Phase of the overcurrent latch
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // no overcurrent fault held
        PH_HOLD  = 2'd1,   // fault held, trip still qualified
        PH_COUNT = 2'd2    // fault held, clear delay running
    } ocp_phase_e;

endpackage

// File: rtl/ocp_trip_filter.sv
module ocp_trip_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_raw,
    output logic trip_qual
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(FILT_CYC);
    localparam logic [CW-1:0] RUN_LIM = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          qual;
    } filt_s;

    filt_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!trip_raw) begin
            s_d.run  = '0;
            s_d.qual = 1'b0;
        end else begin
            s_d.run  = (s_q.run == RUN_MAX) ? RUN_MAX : s_q.run + 1'b1;
            s_d.qual = (s_q.run >= RUN_LIM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trip_qual = s_q.qual;
endmodule

// File: rtl/ocp_clear_timer.sv
module ocp_clear_timer
    import ocp_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_qual,
    input  logic [DLY_W-1:0] clr_len,
    output logic             latched
);
    typedef struct packed {
        ocp_phase_e       ph;
        logic [DLY_W-1:0] tmr;
    } tmr_s;

    tmr_s s_d, s_q;
    logic [DLY_W:0] tmr_next;

    always_comb begin
        s_d      = s_q;
        tmr_next = {1'b0, s_q.tmr} + 1'b1;
        unique case (s_q.ph)
            PH_IDLE: begin
                s_d.tmr = '0;
                if (trip_qual) s_d.ph = PH_HOLD;
            end
            PH_HOLD: begin
                s_d.tmr = '0;
                if (!trip_qual) begin
                    if (clr_len <= DLY_W'(1)) begin
                        s_d.ph = PH_IDLE;
                    end else begin
                        s_d.ph  = PH_COUNT;
                        s_d.tmr = DLY_W'(1);
                    end
                end
            end
            PH_COUNT: begin
                if (trip_qual) begin
                    s_d.ph  = PH_HOLD;
                    s_d.tmr = '0;
                end else if (tmr_next >= {1'b0, clr_len}) begin
                    s_d.ph  = PH_IDLE;
                    s_d.tmr = '0;
                end else begin
                    s_d.tmr = tmr_next[DLY_W-1:0];
                end
            end
            default: begin
                s_d.ph  = PH_IDLE;
                s_d.tmr = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, tmr: '0};
        else        s_q <= s_d;
    end

    assign latched = (s_q.ph != PH_IDLE);
endmodule

// File: rtl/ocp_fault_merge.sv
module ocp_fault_merge (
    input  logic trip_qual,
    input  logic latched,
    input  logic uv_flag,
    output logic fault_n,
    output logic shutdown
);
    logic any_fault;

    always_comb begin
        any_fault = trip_qual | latched | uv_flag;
        fault_n   = ~any_fault;
        shutdown  = any_fault;
    end
endmodule

// File: rtl/ocp_fault_guard.sv
module ocp_fault_guard #(
    parameter int FILT_CYC = 4,
    parameter int DLY_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_raw,
    input  logic             uv_flag,
    input  logic [DLY_W-1:0] clr_len,
    output logic             fault_n,
    output logic             shutdown
);
    logic trip_qual;
    logic oc_latched;

    ocp_trip_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_raw  (trip_raw),
        .trip_qual (trip_qual)
    );

    ocp_clear_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_qual (trip_qual),
        .clr_len   (clr_len),
        .latched   (oc_latched)
    );

    ocp_fault_merge u_merge (
        .trip_qual (trip_qual),
        .latched   (oc_latched),
        .uv_flag   (uv_flag),
        .fault_n   (fault_n),
        .shutdown  (shutdown)
    );
endmodule

// File: rtl/ocp_fault_guard_chk.sv
module ocp_fault_guard_chk #(
    parameter int FILT_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic trip_raw,
    input logic uv_flag,
    input logic qual,
    input logic latched,
    input logic fault_n,
    input logic shutdown
);
    localparam int HW = $clog2(FILT_CYC + 1);
    localparam logic [HW-1:0] HI_MAX = HW'(FILT_CYC);

    logic [HW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hi_q <= '0;
        else if (!trip_raw) hi_q <= '0;
        else if (hi_q != HI_MAX) hi_q <= hi_q + 1'b1;
    end

    AST_SHUTDOWN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown == !fault_n); // R8
    AST_UV_FORCES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |-> !fault_n); // R7
    AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!qual && !latched && !uv_flag) |-> fault_n); // R7
    AST_QUAL_FORCES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> !fault_n); // R3
    AST_FILTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> (hi_q == HI_MAX)); // R2
    AST_SET_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> latched); // R4
    AST_NO_CLEAR_IN_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latched) |-> !$past(qual)); // R6
endmodule

bind ocp_fault_guard ocp_fault_guard_chk #(.FILT_CYC(FILT_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trip_raw (trip_raw),
    .uv_flag  (uv_flag),
    .qual     (trip_qual),
    .latched  (oc_latched),
    .fault_n  (fault_n),
    .shutdown (shutdown)
);

// File: tb/ocp_fault_guard_test.sv
module ocp_fault_guard_test;
    localparam int CLK_P  = 10;
    localparam int FILT   = 4;
    localparam int DW     = 16;
    localparam int NVEC   = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trip_raw = 1'b0;
    logic          uv_flag = 1'b0;
    logic [DW-1:0] clr_len = 16'd3;
    logic          fault_n;
    logic          shutdown;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    ocp_fault_guard #(.FILT_CYC(FILT), .DLY_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .trip_raw(trip_raw), .uv_flag(uv_flag),
        .clr_len(clr_len), .fault_n(fault_n), .shutdown(shutdown)
    );

    // {trip, uv, expected fault_n, requirement number}, clr_len = 3
    localparam logic [6:0] VEC [NVEC] = '{
        {1'b0,1'b0,1'b1,4'd1},  // R1 idle
        {1'b1,1'b0,1'b1,4'd2},  // R2 short burst of FILT-1
        {1'b1,1'b0,1'b1,4'd2},
        {1'b1,1'b0,1'b1,4'd2},
        {1'b0,1'b0,1'b1,4'd2},  // R2 gap restarts count
        {1'b1,1'b0,1'b1,4'd2},
        {1'b1,1'b0,1'b1,4'd2},
        {1'b1,1'b0,1'b1,4'd2},
        {1'b1,1'b0,1'b1,4'd2},  // fourth sample qualifies at this edge
        {1'b1,1'b0,1'b0,4'd3},  // R3 fault from qualifying edge
        {1'b0,1'b0,1'b0,4'd5},  // R5 edge F
        {1'b0,1'b0,1'b0,4'd5},
        {1'b0,1'b0,1'b0,4'd5},
        {1'b0,1'b0,1'b0,4'd5},
        {1'b0,1'b0,1'b1,4'd5},  // R5 released after F+3
        {1'b0,1'b1,1'b0,4'd7},  // R7 immediate undervoltage
        {1'b0,1'b0,1'b1,4'd7},  // R7 immediate release
        {1'b1,1'b0,1'b1,4'd2},
        {1'b1,1'b0,1'b1,4'd2},
        {1'b1,1'b0,1'b1,4'd2},
        {1'b1,1'b0,1'b1,4'd2},
        {1'b0,1'b0,1'b0,4'd3},  // R3 still qualified
        {1'b0,1'b0,1'b0,4'd5},
        {1'b0,1'b0,1'b0,4'd5},
        {1'b0,1'b1,1'b0,4'd7},  // R7 uv during countdown
        {1'b0,1'b0,1'b1,4'd5}
    };

    task automatic step(input logic t, input logic u);
        @(negedge clk);
        trip_raw = t;
        uv_flag  = u;
        #1;
    endtask

    task automatic check(input logic exp_fn, input int req, input string what);
        checks++;
        if (fault_n !== exp_fn || shutdown !== ~exp_fn) begin
            fails++;
            $display("FAIL R%0d %s: fault_n=%b shutdown=%b expected fault_n=%b shutdown=%b",
                     req, what, fault_n, shutdown, exp_fn, ~exp_fn);
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        #(CLK_P * 20000);
        fails++;
        $display("FAIL watchdog: run still active, expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        #(CLK_P * 2 + 1);
        check(1'b1, 1, "during reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(1'b1, 1, "after reset release");

        // Table walk (R2 R3 R5 R7 R8 via shutdown compare)
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][6], VEC[i][5]);
            check(VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
        end

        // R4: trip held long with clr_len = 2 never releases
        clr_len = 16'd2;
        for (int i = 0; i < 60; i++) begin
            step(1'b1, 1'b0);
            if (i >= FILT) check(1'b0, 4, "set-dominant hold");
        end
        step(1'b0, 1'b0); check(1'b0, 4, "edge F pending");
        step(1'b0, 1'b0); check(1'b0, 5, "hold after F");
        step(1'b0, 1'b0); check(1'b0, 5, "count after F+1");
        step(1'b0, 1'b0); check(1'b1, 5, "release after F+2");

        // R6: retrigger during a 20 cycle countdown restarts from zero
        clr_len = 16'd20;
        for (int i = 0; i < FILT + 1; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 10; i++) begin
            step(1'b0, 1'b0);
            if (i > 0) check(1'b0, 6, "first countdown");
        end
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 1'b0);
            check(1'b0, 6, "retrigger");
        end
        for (int j = 0; j <= 21; j++) begin
            step(1'b0, 1'b0);
            check((j == 21) ? 1'b1 : 1'b0, 6, $sformatf("restarted countdown j=%0d", j));
        end

        // R9: clr_len of 0 and 1 both release after F+1
        for (int k = 0; k < 2; k++) begin
            clr_len = DW'(k);
            for (int i = 0; i < FILT + 1; i++) step(1'b1, 1'b0);
            step(1'b0, 1'b0); check(1'b0, 9, "short delay edge F pending");
            step(1'b0, 1'b0); check(1'b0, 9, "short delay after F");
            step(1'b0, 1'b0); check(1'b1, 9, "short delay release after F+1");
        end

        // R1: reset while latched
        clr_len = 16'd50;
        for (int i = 0; i < FILT + 2; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check(1'b0, 1, "latched before reset");
        rst_n = 1'b0;
        #1;
        check(1'b1, 1, "reset clears latch");
        step(1'b0, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        check(1'b1, 1, "idle after mid-fault reset");

        summary();
        $finish;
    end
endmodule